// File: doc/BRIEF.md
# Receive FIFO Status, Timeout and Flow-Control Unit

This unit sits between a serial receiver and a CPU read port. It holds received bytes in a small FIFO, keeps a fill count with empty and full flags, and raises a data-available flag once the fill reaches a programmable trigger level. An idle timer, clocked by a bit-period tick, flags bytes that have sat unread with no new arrivals. A byte offered while the FIFO is full is dropped and latches a sticky overflow flag.

The unit also drives the request-to-send pin. With automatic flow control on, the pin drops to its inactive level once the fill count reaches a programmable threshold. With it off, a software request bit sets the pin. The pin's active polarity can be selected. A FIFO reset request empties the storage and holds the FIFO cleared for three clock cycles, then the unit accepts bytes again.

Top module: `rx_fifo_ctrl`

## Requirements
- R1: `count_o` rises by one for each accepted received byte and falls by one for each read of a non-empty FIFO. `empty_o` is high exactly when the count is 0. `full_o` is high exactly when the count equals DEPTH.
- R2: A read together with an accepted receive in one cycle leaves the count unchanged. A read of a non-empty FIFO presents the oldest byte on `rd_data_o` one cycle later. A read of an empty FIFO leaves `rd_data_o` and the count unchanged.
- R3: `rda_o` is high while the count is at or above the trigger level. Trigger codes map as 0 = 1 byte, 1 = 4, 2 = 8, and any other code = 14 bytes. The level is capped at DEPTH.
- R4: A byte arriving while the FIFO is full, with no read in the same cycle, is dropped and sets `ovf_o`. `ovf_o` stays set until `ovf_clr_i` is pulsed. If both happen in one cycle, the set wins.
- R5: The idle counter advances by one on each `bit_tick_i` while the FIFO holds data. `tout_o` is high while the counter equals `to_cmp_i`, the FIFO is non-empty and the timer is enabled.
- R6: An accepted byte, an empty FIFO or a cleared `to_en_i` returns the idle counter to zero. With `to_en_i` low, `tout_o` stays low.
- R7: With `auto_rts_en_i` high, RTS is asserted while the count is below the RTS level and deasserted at or above it. RTS codes map as 0 = 1 byte, 1 = 4, 2 = 8, and any other code = 14 bytes, capped at DEPTH.
- R8: `rts_o` equals `rts_act_hi_i` when RTS is asserted and its inverse when RTS is deasserted. With auto flow control off, `rts_force_i` sets whether RTS is asserted.
- R9: A `fifo_rst_i` pulse empties the FIFO at the next edge. `rst_busy_o` is then high for exactly 3 cycles. While the request or busy is active, received bytes and reads are ignored and no overflow is raised.
- R10: After `rst_ni` is asserted, the count, flags, read data and idle counter are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Received-byte strobe |
| rx_data_i | input | DATA_W | Received byte |
| rd_en_i | input | 1 | CPU read strobe |
| rd_data_o | output | DATA_W | Last byte read |
| bit_tick_i | input | 1 | One pulse per bit period |
| trig_lvl_i | input | 4 | Data-available trigger code |
| rts_lvl_i | input | 4 | RTS threshold code |
| to_cmp_i | input | TO_W | Idle timeout compare value |
| to_en_i | input | 1 | Idle timer enable |
| auto_rts_en_i | input | 1 | Automatic RTS flow control enable |
| rts_force_i | input | 1 | Software RTS request when auto is off |
| rts_act_hi_i | input | 1 | 1 = RTS active high, 0 = active low |
| fifo_rst_i | input | 1 | FIFO reset request pulse |
| ovf_clr_i | input | 1 | Write-one clear of the overflow flag |
| count_o | output | CNT_W | FIFO fill count |
| empty_o | output | 1 | FIFO empty |
| full_o | output | 1 | FIFO full |
| rda_o | output | 1 | Data-available flag |
| tout_o | output | 1 | Idle timeout flag |
| ovf_o | output | 1 | Sticky overflow flag |
| rst_busy_o | output | 1 | FIFO reset in progress |
| rts_o | output | 1 | RTS pin |

## Verification
Some results are registered and appear one clock edge after the strobe that causes them: the count, read data, overflow, busy and idle counter. The data-available, timeout, empty/full and RTS outputs are combinational, so they follow the registered count and the configuration inputs in the same cycle. The bench drives every input just after a falling edge. Its behavioural model advances on the rising edge using those held inputs. All outputs are compared 1 ns after the next falling edge, so each registered result is checked in the cycle it is due, and each combinational result is checked against the inputs currently applied.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  // byte threshold for a 4-bit level code, capped at depth
  function automatic int unsigned level_of(input logic [3:0] code, input int unsigned depth);
    int unsigned lv;
    case (code)
      4'd0:    lv = 1;
      4'd1:    lv = 4;
      4'd2:    lv = 8;
      default: lv = 14;
    endcase
    return (lv > depth) ? depth : lv;
  endfunction
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              push_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              push, pop, ovf_set;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign push    = wr_i && !clr_i && (!full_o || rd_i);
  assign pop     = rd_i && !clr_i && !empty_o;
  assign ovf_set = wr_i && !clr_i && full_o && !rd_i;
  assign push_o  = push;
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      cnt_q     <= '0;
      rd_data_o <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= nxt(wptr_q);
      if (pop) begin
        rptr_q    <= nxt(rptr_q);
        rd_data_o <= mem_q[rptr_q];
      end
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_o <= 1'b0;
    else if (ovf_set)   ovf_o <= 1'b1;
    else if (ovf_clr_i) ovf_o <= 1'b0;
  end

  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(clr_i) && cnt_q != $past(cnt_q)) |->
      (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == $past(cnt_q) - 1'b1));
  a_r2_empty_read_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_o) |=> $stable(rd_data_o));
  a_r4_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int unsigned TO_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            empty_i,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic [TO_W-1:0] cmp_i,
  output logic            tout_o
);
  logic [TO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (push_i || empty_i || !en_i)   cnt_q <= '0;
    else if (tick_i && cnt_q != cmp_i)     cnt_q <= cnt_q + 1'b1;
  end

  assign tout_o = en_i && !empty_i && (cnt_q == cmp_i);

  a_r5_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));
  a_r6_off_stays_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> (cnt_q == '0));
endmodule

// File: rtl/rx_rts_ctrl.sv
module rx_rts_ctrl #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] lvl_i,
  input  logic             auto_i,
  input  logic             force_i,
  input  logic             act_hi_i,
  output logic             rts_o
);
  logic asserted;

  assign asserted = auto_i ? (count_i < lvl_i) : force_i;
  assign rts_o    = act_hi_i ? asserted : !asserted;

  a_r7_stop_at_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && count_i >= lvl_i) |-> (rts_o == !act_hi_i));
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned TO_W    = 7,
  parameter int unsigned RST_CYC = 3,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned RC_W   = $clog2(RST_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              bit_tick_i,
  input  logic [3:0]        trig_lvl_i,
  input  logic [3:0]        rts_lvl_i,
  input  logic [TO_W-1:0]   to_cmp_i,
  input  logic              to_en_i,
  input  logic              auto_rts_en_i,
  input  logic              rts_force_i,
  input  logic              rts_act_hi_i,
  input  logic              fifo_rst_i,
  input  logic              ovf_clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              rda_o,
  output logic              tout_o,
  output logic              ovf_o,
  output logic              rst_busy_o,
  output logic              rts_o
);
  logic [RC_W-1:0]  rc_q;
  logic             clr, push;
  logic [CNT_W-1:0] trig_cnt, rts_cnt;

  // self-clearing reset request: hold FIFO clear for RST_CYC cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rc_q <= '0;
    else if (rc_q != '0)                 rc_q <= rc_q - 1'b1;
    else if (fifo_rst_i)                 rc_q <= RC_W'(RST_CYC);
  end
  assign rst_busy_o = (rc_q != '0);
  assign clr        = fifo_rst_i || rst_busy_o;

  assign trig_cnt = CNT_W'(level_of(trig_lvl_i, DEPTH));
  assign rts_cnt  = CNT_W'(level_of(rts_lvl_i, DEPTH));

  rx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .clr_i     (clr),
    .wr_i      (rx_valid_i),
    .wr_data_i (rx_data_i),
    .rd_i      (rd_en_i),
    .ovf_clr_i (ovf_clr_i),
    .rd_data_o (rd_data_o),
    .count_o   (count_o),
    .empty_o   (empty_o),
    .full_o    (full_o),
    .ovf_o     (ovf_o),
    .push_o    (push)
  );

  rx_idle_timer #(.TO_W(TO_W)) u_timer (
    .clk_i, .rst_ni,
    .push_i  (push),
    .empty_i (empty_o),
    .en_i    (to_en_i),
    .tick_i  (bit_tick_i),
    .cmp_i   (to_cmp_i),
    .tout_o  (tout_o)
  );

  rx_rts_ctrl #(.CNT_W(CNT_W)) u_rts (
    .clk_i, .rst_ni,
    .count_i  (count_o),
    .lvl_i    (rts_cnt),
    .auto_i   (auto_rts_en_i),
    .force_i  (rts_force_i),
    .act_hi_i (rts_act_hi_i),
    .rts_o    (rts_o)
  );

  assign rda_o = (count_o >= trig_cnt);

  a_r9_clear_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_busy_o |-> (count_o == '0));
  a_r9_busy_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rst_i && !rst_busy_o) |=> rst_busy_o);
  a_r9_no_ovf_in_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !ovf_o) |=> !ovf_o);
  a_r6_empty_no_tout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |-> !tout_o);
endmodule

// File: tb/tb_rx_fifo_ctrl.sv
module tb_rx_fifo_ctrl;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_ni = 1'b1;
  logic rx_valid = 0, rd_en = 0, tick = 0, to_en = 1, auto_rts = 1, rts_force = 0;
  logic act_hi = 0, fifo_rst = 0, ovf_clr = 0;
  logic [7:0] rx_data = 0;
  logic [3:0] trig = 0, rts_lvl = 2;
  logic [6:0] to_cmp = 5;
  logic [7:0] rd_data;
  logic [4:0] count;
  logic empty, full, rda, tout, ovf, busy, rts;

  int nchk = 0, nfail = 0;
  bit chk_en = 0, done = 0;

  always #2 clk = ~clk;

  rx_fifo_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .bit_tick_i(tick), .trig_lvl_i(trig),
    .rts_lvl_i(rts_lvl), .to_cmp_i(to_cmp), .to_en_i(to_en), .auto_rts_en_i(auto_rts),
    .rts_force_i(rts_force), .rts_act_hi_i(act_hi), .fifo_rst_i(fifo_rst),
    .ovf_clr_i(ovf_clr), .count_o(count), .empty_o(empty), .full_o(full),
    .rda_o(rda), .tout_o(tout), .ovf_o(ovf), .rst_busy_o(busy), .rts_o(rts)
  );

  // behavioural reference
  logic [7:0] q[$];
  logic [7:0] m_last = 0;
  bit m_ovf = 0;
  int m_to = 0, m_busy = 0;

  function automatic int lvl(input logic [3:0] c);
    int v;
    v = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
    return (v > DEPTH) ? DEPTH : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      q.delete(); m_last = 0; m_ovf = 0; m_to = 0; m_busy = 0;
    end else begin
      bit clr, push, pop, ovs;
      int sz;
      clr  = fifo_rst || (m_busy > 0);
      sz   = q.size();
      push = rx_valid && !clr && (sz < DEPTH || (rd_en && sz > 0));
      pop  = rd_en && !clr && sz > 0;
      ovs  = rx_valid && !clr && sz == DEPTH && !rd_en;
      if (push || sz == 0 || !to_en) m_to = 0;
      else if (tick && m_to != int'(to_cmp)) m_to = (m_to + 1) % 128;
      if (pop) m_last = q.pop_front();
      if (push) q.push_back(rx_data);
      if (ovs) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      if (m_busy > 0) m_busy--;
      else if (fifo_rst) m_busy = 3;
      if (clr) q.delete();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (chk_en && !done) begin
      int sz;
      bit asrt;
      sz = q.size();
      if (!rst_ni) chk("R10 count in reset", 32'(count), 0);
      chk("R1 count", 32'(count), 32'(sz));
      chk("R1 empty", 32'(empty), 32'(sz == 0));
      chk("R1 full", 32'(full), 32'(sz == DEPTH));
      chk("R2 rd_data", 32'(rd_data), 32'(m_last));
      chk("R3 rda", 32'(rda), 32'(sz >= lvl(trig)));
      chk("R4 ovf", 32'(ovf), 32'(m_ovf));
      chk("R5 R6 tout", 32'(tout), 32'(to_en && sz > 0 && m_to == int'(to_cmp)));
      chk("R9 busy", 32'(busy), 32'(m_busy > 0));
      asrt = auto_rts ? (sz < lvl(rts_lvl)) : rts_force;
      chk("R7 R8 rts", 32'(rts), 32'(act_hi ? asrt : !asrt));
    end
  end

  task automatic step(input bit v, input bit r, input bit t);
    @(negedge clk);
    rx_valid = v; rd_en = r; tick = t; rx_data = 8'($urandom);
    fifo_rst = 0; ovf_clr = 0;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #1 rst_ni = 0;
    chk_en = 1;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R5: three bytes then idle bit periods until timeout
    repeat (3) step(1, 0, 1);
    repeat (10) step(0, 0, 1);
    // R6: new byte restarts the counter; then disable
    step(1, 0, 1);
    repeat (3) step(0, 0, 1);
    @(negedge clk) to_en = 0;
    repeat (8) step(0, 0, 1);
    @(negedge clk) to_en = 1;
    // R2: drain, then read empty
    repeat (4) step(0, 1, 0);
    repeat (3) step(0, 1, 0);
    // R1 R3 R4 R7: fill past full with trigger code 1
    @(negedge clk) trig = 1;
    repeat (DEPTH + 3) step(1, 0, 0);
    step(1, 1, 0);               // R2 simultaneous at full
    @(negedge clk) ovf_clr = 1;  // R4 clear
    step(0, 0, 0);
    // R8: polarity and manual request
    @(negedge clk) act_hi = 1;
    step(0, 0, 0);
    @(negedge clk) begin auto_rts = 0; rts_force = 1; end
    step(0, 0, 0);
    @(negedge clk) rts_force = 0;
    step(0, 0, 0);
    @(negedge clk) begin auto_rts = 1; act_hi = 0; end
    // R9: reset request with traffic arriving
    @(negedge clk) begin fifo_rst = 1; rx_valid = 1; end
    repeat (5) step(1, 1, 0);
    repeat (3) step(1, 0, 0);
    // random traffic and configuration
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      rx_valid = ($urandom % 100) < 45;
      rd_en    = ($urandom % 100) < 40;
      tick     = ($urandom % 4) == 0;
      rx_data  = 8'($urandom);
      ovf_clr  = ($urandom % 40) == 0;
      fifo_rst = ($urandom % 300) == 0;
      if (($urandom % 200) == 0) begin
        trig = 4'($urandom); rts_lvl = 4'($urandom); to_cmp = 7'($urandom % 12);
        to_en = ($urandom % 5) != 0; auto_rts = ($urandom % 4) != 0;
        rts_force = 1'($urandom); act_hi = 1'($urandom);
      end
    end
    step(0, 0, 0);
    repeat (2) @(negedge clk);
    #2 done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule